// File: doc/BRIEF.md
# Page Access Permission Checker

This block rules on one memory access per request. It decides whether the access goes through address translation and whether the page table entry permits it. The inputs are the hart's current privilege, the status controls (modify-privilege enable, previous privilege, supervisor-user access, make-executable-readable), the translation enable bit, the access kind, the virtual address and the fields of the leaf page table entry already found for that address. It returns the physical address, a flag saying translation was applied and a page-fault flag.

A load/store unit or a fetch unit presents a request together with the entry its lookup produced. One cycle later the registered verdict appears together with a single-cycle response strobe. Walking the tables, caching entries and updating accessed or dirty bits belong to the neighbours.

The default geometry uses a 32-bit virtual address, a 22-bit frame number split into a 12-bit upper part and a 10-bit lower part, 4 KiB pages and 4 MiB superpages, which gives a 34-bit physical address.

Top module: `vm_access_check`

## Requirements
- R1: During and after a synchronous active-high reset, with no request yet made, `rsp_valid`, `rsp_xlate`, `rsp_fault` and `rsp_pa` are all 0.
- R2: A request sampled with `req_valid` high at a rising edge yields `rsp_valid` high for exactly the following cycle, with the verdict for that request on the other outputs. A cycle without a request yields `rsp_valid` low, and the other outputs keep the last verdict.
- R3: Privilege codes are 0 user, 1 supervisor and 3 machine. The effective privilege is `st_mpp` when `st_mprv` is set and the access kind is not a fetch; otherwise it is `cur_priv`. Code 2 translates and is subject to neither rule of R6.
- R4: When the effective privilege is 3 or `xlate_on` is 0, `rsp_xlate` is 0, `rsp_fault` is 0 and `rsp_pa` is the virtual address zero-extended, whatever the entry holds. In particular, a machine-mode fetch never translates, and a machine-mode data access translates only under `st_mprv`.
- R5: A translated access whose entry has `pte_valid` clear faults.
- R6: A translated access faults when the entry lacks U and the effective privilege is 0, or when the entry has U, the effective privilege is 1 and `st_sum` is 0.
- R7: A translated access to a superpage entry (`pte_super` = 1) whose lower 10 frame-number bits are not all zero faults.
- R8: Access kind codes are 00 read, 01 write, 10 fetch and 11 reserved. A translated read needs R, or X together with `st_mxr`. A write needs W and a fetch needs X. The reserved code always faults when translated.
- R9: A translated access that does not fault returns {frame number, VA[11:0]} for a 4 KiB page and {upper 12 frame bits, VA[21:0]} for a superpage. A faulting response returns 0 as the physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 reserved |
| cur_priv | input | 2 | Current privilege |
| st_mprv | input | 1 | Data accesses use the previous privilege |
| st_mpp | input | 2 | Previous privilege field |
| st_sum | input | 1 | Supervisor may touch user pages |
| st_mxr | input | 1 | Executable pages count as readable |
| xlate_on | input | 1 | Translation mode enable |
| va | input | 32 | Virtual address |
| pte_valid | input | 1 | Entry valid bit |
| pte_r | input | 1 | Entry read permission |
| pte_w | input | 1 | Entry write permission |
| pte_x | input | 1 | Entry execute permission |
| pte_u | input | 1 | Entry user-page bit |
| pte_super | input | 1 | Entry maps a superpage |
| pte_ppn | input | 22 | Entry frame number |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_pa | output | 34 | Physical address |
| rsp_xlate | output | 1 | Translation was applied |
| rsp_fault | output | 1 | Page fault |

## Verification
Each response depends only on the request registered one cycle earlier, so a wrong effective-privilege choice or a wrong permission term appears at the ports on the very next strobe as a flipped `rsp_fault` or `rsp_xlate`, or as an address that does not equal the bypassed virtual address. A stuck or misaligned response register shows up as `rsp_valid` missing, doubled or out of step with `req_valid`. Random stimulus crosses every privilege, control bit and entry field, and directed cases pin down machine-mode fetch, the previous-privilege path, the supervisor-user and make-executable-readable controls, and superpage alignment.

// File: rtl/vmc_pkg.sv
package vmc_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  localparam logic [1:0] PRIV_USER = 2'd0;
  localparam logic [1:0] PRIV_SUP  = 2'd1;
  localparam logic [1:0] PRIV_MACH = 2'd3;

  typedef struct packed {
    logic valid;
    logic r;
    logic w;
    logic x;
    logic u;
  } pte_perm_t;
endpackage

// File: rtl/vmc_priv_sel.sv
module vmc_priv_sel
  import vmc_pkg::*;
(
  input  acc_kind_e  kind,
  input  logic [1:0] cur_priv,
  input  logic       mprv,
  input  logic [1:0] mpp,
  input  logic       xlate_on,
  output logic [1:0] eff_priv,
  output logic       need_xlate
);
  always_comb begin
    if (mprv && (kind != ACC_FETCH)) eff_priv = mpp;
    else                             eff_priv = cur_priv;
    need_xlate = xlate_on && (eff_priv != PRIV_MACH);
  end
endmodule

// File: rtl/vmc_perm_chk.sv
module vmc_perm_chk
  import vmc_pkg::*;
#(
  parameter int PPN0_W = 10
) (
  input  acc_kind_e          kind,
  input  logic [1:0]         eff_priv,
  input  logic               sum,
  input  logic               mxr,
  input  pte_perm_t          perm,
  input  logic               is_super,
  input  logic [PPN0_W-1:0]  ppn_low,
  output logic               deny
);
  logic kind_ok;
  logic user_bad;
  logic align_bad;

  always_comb begin
    unique case (kind)
      ACC_READ:  kind_ok = perm.r || (mxr && perm.x);
      ACC_WRITE: kind_ok = perm.w;
      ACC_FETCH: kind_ok = perm.x;
      default:   kind_ok = 1'b0;
    endcase
    user_bad  = (!perm.u && eff_priv == PRIV_USER) ||
                (perm.u && eff_priv == PRIV_SUP && !sum);
    align_bad = is_super && (ppn_low != '0);
    deny      = !perm.valid || user_bad || align_bad || !kind_ok;
  end
endmodule

// File: rtl/vmc_pa_build.sv
module vmc_pa_build #(
  parameter int VA_W   = 32,
  parameter int OFS_W  = 12,
  parameter int PPN0_W = 10,
  parameter int PPN1_W = 12,
  localparam int PPN_W   = PPN0_W + PPN1_W,
  localparam int PA_W    = PPN_W + OFS_W,
  localparam int SOFS_W  = OFS_W + PPN0_W
) (
  input  logic [VA_W-1:0]  va,
  input  logic [PPN_W-1:0] ppn,
  input  logic             is_super,
  input  logic             translate,
  output logic [PA_W-1:0]  pa
);
  logic [PA_W-1:0] pa_bypass;

  generate
    if (PA_W >= VA_W) begin : g_wide
      assign pa_bypass = {{(PA_W-VA_W){1'b0}}, va};
    end else begin : g_narrow
      assign pa_bypass = va[PA_W-1:0];
    end
  endgenerate

  always_comb begin
    if (!translate)    pa = pa_bypass;
    else if (is_super) pa = {ppn[PPN_W-1:PPN0_W], va[SOFS_W-1:0]};
    else               pa = {ppn, va[OFS_W-1:0]};
  end
endmodule

// File: rtl/vm_access_check.sv
module vm_access_check
  import vmc_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int OFS_W  = 12,
  parameter int PPN0_W = 10,
  parameter int PPN1_W = 12,
  localparam int PPN_W = PPN0_W + PPN1_W,
  localparam int PA_W  = PPN_W + OFS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [1:0]       cur_priv,
  input  logic             st_mprv,
  input  logic [1:0]       st_mpp,
  input  logic             st_sum,
  input  logic             st_mxr,
  input  logic             xlate_on,
  input  logic [VA_W-1:0]  va,
  input  logic             pte_valid,
  input  logic             pte_r,
  input  logic             pte_w,
  input  logic             pte_x,
  input  logic             pte_u,
  input  logic             pte_super,
  input  logic [PPN_W-1:0] pte_ppn,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_xlate,
  output logic             rsp_fault
);
  acc_kind_e       kind;
  logic [1:0]      eff_priv;
  logic            need_xlate;
  logic            deny;
  pte_perm_t       perm;
  logic [PA_W-1:0] pa_raw;
  logic            fault_n;

  assign kind = acc_kind_e'(req_kind);
  assign perm = '{valid: pte_valid, r: pte_r, w: pte_w, x: pte_x, u: pte_u};

  vmc_priv_sel u_priv (
    .kind       (kind),
    .cur_priv   (cur_priv),
    .mprv       (st_mprv),
    .mpp        (st_mpp),
    .xlate_on   (xlate_on),
    .eff_priv   (eff_priv),
    .need_xlate (need_xlate)
  );

  vmc_perm_chk #(.PPN0_W(PPN0_W)) u_perm (
    .kind     (kind),
    .eff_priv (eff_priv),
    .sum      (st_sum),
    .mxr      (st_mxr),
    .perm     (perm),
    .is_super (pte_super),
    .ppn_low  (pte_ppn[PPN0_W-1:0]),
    .deny     (deny)
  );

  vmc_pa_build #(
    .VA_W(VA_W), .OFS_W(OFS_W), .PPN0_W(PPN0_W), .PPN1_W(PPN1_W)
  ) u_pa (
    .va        (va),
    .ppn       (pte_ppn),
    .is_super  (pte_super),
    .translate (need_xlate),
    .pa        (pa_raw)
  );

  assign fault_n = need_xlate && deny;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_xlate <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_xlate <= need_xlate;
        rsp_fault <= fault_n;
        rsp_pa    <= fault_n ? '0 : pa_raw;
      end
    end
  end
endmodule

// File: rtl/vmc_checker.sv
module vmc_checker #(
  parameter int VA_W = 32,
  parameter int PA_W = 34
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [1:0]      req_kind,
  input logic [1:0]      cur_priv,
  input logic            st_mprv,
  input logic            xlate_on,
  input logic [VA_W-1:0] va,
  input logic            pte_valid,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_pa,
  input logic            rsp_xlate,
  input logic            rsp_fault
);
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r2_no_rsp_when_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  a_r4_mach_fetch_bypass: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'b10 && cur_priv == 2'd3) |=> (!rsp_xlate && !rsp_fault));
  a_r4_bypass_pa: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !xlate_on) |=> (rsp_pa == PA_W'($past(va)) && !rsp_fault));
  a_r5_invalid_faults: assert property (@(posedge clk) disable iff (rst)
    (req_valid && xlate_on && !st_mprv && cur_priv == 2'd0 && !pte_valid) |=> rsp_fault);
  a_r9_fault_zero_pa: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_xlate && rsp_pa == '0));
endmodule

bind vm_access_check vmc_checker #(.VA_W(VA_W), .PA_W(PA_W)) u_vmc_checker (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .cur_priv  (cur_priv),
  .st_mprv   (st_mprv),
  .xlate_on  (xlate_on),
  .va        (va),
  .pte_valid (pte_valid),
  .rsp_valid (rsp_valid),
  .rsp_pa    (rsp_pa),
  .rsp_xlate (rsp_xlate),
  .rsp_fault (rsp_fault)
);

// File: tb/vm_access_check_bench.sv
module vm_access_check_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [1:0]  cur_priv = '0;
  logic        st_mprv = 1'b0;
  logic [1:0]  st_mpp = '0;
  logic        st_sum = 1'b0;
  logic        st_mxr = 1'b0;
  logic        xlate_on = 1'b0;
  logic [31:0] va = '0;
  logic        pte_valid = 1'b0, pte_r = 1'b0, pte_w = 1'b0, pte_x = 1'b0;
  logic        pte_u = 1'b0, pte_super = 1'b0;
  logic [21:0] pte_ppn = '0;
  logic        rsp_valid, rsp_xlate, rsp_fault;
  logic [33:0] rsp_pa;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vm_access_check u_vm_access_check (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .cur_priv(cur_priv), .st_mprv(st_mprv), .st_mpp(st_mpp), .st_sum(st_sum),
    .st_mxr(st_mxr), .xlate_on(xlate_on), .va(va), .pte_valid(pte_valid),
    .pte_r(pte_r), .pte_w(pte_w), .pte_x(pte_x), .pte_u(pte_u),
    .pte_super(pte_super), .pte_ppn(pte_ppn), .rsp_valid(rsp_valid),
    .rsp_pa(rsp_pa), .rsp_xlate(rsp_xlate), .rsp_fault(rsp_fault)
  );

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected verdict from R3..R9
  task automatic model(output logic ex, output logic fl, output logic [33:0] pa);
    logic [1:0] eff;
    logic ok;
    eff = (st_mprv && req_kind != 2'b10) ? st_mpp : cur_priv;
    ex  = xlate_on && eff != 2'd3;
    case (req_kind)
      2'b00: ok = pte_r || (st_mxr && pte_x);
      2'b01: ok = pte_w;
      2'b10: ok = pte_x;
      default: ok = 1'b0;
    endcase
    if (!pte_valid) ok = 1'b0;
    if (!pte_u && eff == 2'd0) ok = 1'b0;
    if (pte_u && eff == 2'd1 && !st_sum) ok = 1'b0;
    if (pte_super && pte_ppn[9:0] != 10'd0) ok = 1'b0;
    fl = ex && !ok;
    if (!ex)            pa = {2'b00, va};
    else if (fl)        pa = '0;
    else if (pte_super) pa = {pte_ppn[21:10], va[21:0]};
    else                pa = {pte_ppn, va[11:0]};
  endtask

  task automatic issue(input string tag);
    logic ex, fl;
    logic [33:0] pa;
    model(ex, fl, pa);
    req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    check({tag, " R2 valid"}, 34'(rsp_valid), 34'd1);
    check({tag, " xlate"}, 34'(rsp_xlate), 34'(ex));
    check({tag, " fault"}, 34'(rsp_fault), 34'(fl));
    check({tag, " R9 pa"}, rsp_pa, pa);
  endtask

  task automatic set_pte(input logic v, input logic r, input logic w, input logic x,
                         input logic u, input logic s, input logic [21:0] p);
    pte_valid = v; pte_r = r; pte_w = w; pte_x = x; pte_u = u; pte_super = s; pte_ppn = p;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid", 34'(rsp_valid), 34'd0);
    check("R1 pa", rsp_pa, 34'd0);
    check("R1 xlate", 34'(rsp_xlate), 34'd0);
    check("R1 fault", 34'(rsp_fault), 34'd0);
    rst = 1'b0;
    @(posedge clk); #1;

    // R4 machine fetch ignores translation and a bad entry
    xlate_on = 1; cur_priv = 3; req_kind = 2'b10; va = 32'hDEAD_BEEF;
    set_pte(0, 0, 0, 0, 0, 1, 22'h3FF);
    issue("R4 mfetch");
    check("R4 mfetch nofault", 34'(rsp_fault), 34'd0);
    // R3 machine data with MPRV and MPP user translates
    st_mprv = 1; st_mpp = 0; req_kind = 2'b00; va = 32'h0012_3456;
    set_pte(1, 1, 0, 0, 1, 0, 22'h2_ABCD);
    issue("R3 mprv user");
    check("R3 mprv xlate", 34'(rsp_xlate), 34'd1);
    // R3 fetch ignores MPRV
    req_kind = 2'b10; issue("R3 fetch mprv");
    // R6 supervisor on user page, SUM clear then set
    st_mprv = 0; cur_priv = 1; req_kind = 2'b00; st_sum = 0;
    issue("R6 sum0");
    check("R6 sum0 fault", 34'(rsp_fault), 34'd1);
    st_sum = 1; issue("R6 sum1");
    // R6 user on supervisor page
    cur_priv = 0; pte_u = 0; issue("R6 user spage");
    // R8 MXR read of execute-only page
    cur_priv = 1; set_pte(1, 0, 0, 1, 0, 0, 22'h1_1111);
    st_mxr = 0; issue("R8 mxr0");
    st_mxr = 1; issue("R8 mxr1");
    check("R8 mxr1 ok", 34'(rsp_fault), 34'd0);
    req_kind = 2'b01; issue("R8 write no W");
    req_kind = 2'b11; set_pte(1, 1, 1, 1, 0, 0, 22'h0_0001); issue("R8 rsvd");
    // R7 superpage alignment, R9 superpage address
    req_kind = 2'b00; va = 32'hABCD_EF12;
    set_pte(1, 1, 0, 0, 0, 1, 22'h15_5400); issue("R9 super ok");
    set_pte(1, 1, 0, 0, 0, 1, 22'h15_5401); issue("R7 super mis");
    // R5 invalid entry
    set_pte(0, 1, 1, 1, 0, 0, 22'h0_0ABC); issue("R5 invalid");
    // R4 translation off
    xlate_on = 0; issue("R4 off");
    // R2 idle cycle: no strobe, outputs held
    @(posedge clk); #1;
    check("R2 idle valid", 34'(rsp_valid), 34'd0);
    check("R2 idle hold", rsp_pa, {2'b00, va});

    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 400; i++) begin
      req_kind = 2'($urandom); cur_priv = 2'($urandom);
      st_mprv = 1'($urandom); st_mpp = 2'($urandom);
      st_sum = 1'($urandom); st_mxr = 1'($urandom);
      xlate_on = ($urandom % 4) != 0; va = $urandom;
      set_pte(($urandom % 5) != 0, 1'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom),
              ($urandom % 2) ? {12'($urandom), 10'd0} : 22'($urandom));
      issue("R8 rand");
      if ($urandom % 4 == 0) begin
        @(posedge clk); #1;
        check("R2 rand idle", 34'(rsp_valid), 34'd0);
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule